// File: doc/BRIEF.md
# Alarm and Event Interrupt Status Controller

This unit gathers alarm and event indications from up to four framer channels. It holds them in status registers that a CPU can read, and it drives a single active-low interrupt line. Each channel has three latched status registers. The first status register mixes four alarm bits, which are level conditions, with four event bits. The second status register holds eight event bits, and a third register holds the events of the channel's HDLC controller. Every status bit has an enable bit in a matching enable register. A further register per channel returns the synchronizer state live, with no latching.

Alarm bits flag an interrupt every time the alarm changes state, whether it appears or clears. An alarm bit keeps reading 1 while the alarm persists. Event bits flag an interrupt when a one-cycle pulse arrives. A read of a status register releases the pending flags of that register only. If an occurrence lands in the same cycle as the read, the occurrence wins and is not lost.

A summary register decodes across the whole upper quarter of the address space. It shows, per channel, whether the channel's ordinary status registers or its HDLC controller currently hold an enabled pending source.

The register bus is combinational on the read side: `rdata_o` reflects `addr_i` in the same cycle. A read strobe clears the pending flags at the next rising clock edge.

Top module: `aic_top`

## Requirements
- R1: The four low bits (3:0) of the first status register (offset 0) are alarms. Any change of an alarm input, rising or falling, sets that bit's pending flag. The bit reads as pending flag OR live alarm level, so it stays 1 while the alarm is present.
- R2: The event bits set a pending flag on a one-cycle high input and read 1 until that register is read. These are bits 7:4 of offset 0 (fed from the 4-bit event input), all bits of offset 1 and all bits of offset 2 (HDLC).
- R3: A read of a status register clears the pending flags of that register only, at the clock edge that ends the read. Other registers keep their flags.
- R4: When an occurrence reaches a bit in the same cycle as a read of its register, the flag stays set after the edge and so does its interrupt request.
- R5: Enable registers sit at offsets 4, 5 and 6 and pair with offsets 0, 1 and 2. They are read and write, and 1 means the bit may interrupt. A pending bit whose enable is 0 neither pulls `irq_n_o` low nor sets a summary bit.
- R6: `irq_n_o` is 0 in the cycle after any enabled pending flag exists in any channel. It is 1 once none remain.
- R7: Offset 3 returns the channel's synchronizer input live in the same cycle, with no latching. Reading it changes nothing.
- R8: Reads at any address 0xC0 to 0xFF return the summary. Bit 2n is channel n's request from offsets 0 and 1, and bit 2n+1 is its HDLC request. Reading the summary has no side effects.
- R9: A synchronous reset clears every pending flag, alarm history and enable bit, so `irq_n_o` is 1 after reset.
- R10: Channel n registers live at 0x10*n + offset, with address bits 7:6 = 00. Addresses 0x40 to 0xBF and channel offsets 7 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe; clears the addressed status flags at the edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_n_o | output | 1 | Interrupt request, active low |
| alm_i | input | NCH*4 | Alarm levels, 4 per channel |
| ev1_i | input | NCH*4 | Event pulses for bits 7:4 of offset 0 |
| ev2_i | input | NCH*8 | Event pulses for offset 1 |
| hev_i | input | NCH*8 | HDLC event pulses for offset 2 |
| sync_i | input | NCH*8 | Live synchronizer state for offset 3 |

## Verification
The hardest case to reach is an occurrence that coincides exactly with the read of its own register. The read data in that cycle still shows the old value, and the flag must survive the clearing edge. The bench raises the read strobe and the event pulse at the same falling edge, samples the old read value, and then checks that the interrupt stays low and that a second read returns the new bit. The removal of an alarm is reached by holding the alarm level across reads, so that the live level keeps the bit visible, and then dropping it. This must raise a fresh request that reads 1 once and 0 after.

// File: rtl/aic_pkg.sv
package aic_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [3:0] {
        OFF_ST1 = 4'd0,
        OFF_ST2 = 4'd1,
        OFF_STH = 4'd2,
        OFF_SYN = 4'd3,
        OFF_EN1 = 4'd4,
        OFF_EN2 = 4'd5,
        OFF_ENH = 4'd6
    } reg_off_e;
endpackage

// File: rtl/aic_statreg.sv
// One latched status register: the low NLVL bits are level inputs that flag
// on any change, the rest are pulse inputs that flag when high.
module aic_statreg #(
    parameter int W    = 8,
    parameter int NLVL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] en_i,
    input  logic         clr_i,
    output logic [W-1:0] val_o,
    output logic         req_o
);
    localparam logic [W-1:0] LVL_MASK = W'((1 << NLVL) - 1);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] hist;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] occur;

    always_comb begin
        occur      = ((src_i ^ st_q.hist) & LVL_MASK) | (src_i & ~LVL_MASK);
        st_d.hist  = src_i;
        // a fresh occurrence outranks the clear of a read in the same cycle
        st_d.pend  = (clr_i ? '0 : st_q.pend) | occur;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign val_o = st_q.pend | (src_i & LVL_MASK);
    assign req_o = |(st_q.pend & en_i);
endmodule

// File: rtl/aic_chan.sv
// Register set of one framer channel.
module aic_chan
    import aic_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int NALM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NALM-1:0] alm_i,
    input  logic [W-NALM-1:0] ev1_i,
    input  logic [W-1:0]    ev2_i,
    input  logic [W-1:0]    hev_i,
    input  logic [W-1:0]    syn_i,
    input  logic            sel_i,
    input  logic [3:0]      off_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [W-1:0]    wdata_i,
    output logic [W-1:0]    rdata_o,
    output logic            sr_req_o,
    output logic            hd_req_o
);
    typedef struct packed {
        logic [W-1:0] en1;
        logic [W-1:0] en2;
        logic [W-1:0] enh;
    } en_t;

    en_t          en_d, en_q;
    reg_off_e     off;
    logic         clr1, clr2, clrh;
    logic         req1, req2;
    logic [W-1:0] val1, val2, valh;

    assign off  = reg_off_e'(off_i);
    assign clr1 = sel_i && rd_i && (off == OFF_ST1);
    assign clr2 = sel_i && rd_i && (off == OFF_ST2);
    assign clrh = sel_i && rd_i && (off == OFF_STH);

    always_comb begin
        en_d = en_q;
        if (sel_i && wr_i) begin
            case (off)
                OFF_EN1: en_d.en1 = wdata_i;
                OFF_EN2: en_d.en2 = wdata_i;
                OFF_ENH: en_d.enh = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    aic_statreg #(.W(W), .NLVL(NALM)) u_st1 (
        .clk(clk), .rst(rst), .src_i({ev1_i, alm_i}), .en_i(en_q.en1),
        .clr_i(clr1), .val_o(val1), .req_o(req1)
    );
    aic_statreg #(.W(W), .NLVL(0)) u_st2 (
        .clk(clk), .rst(rst), .src_i(ev2_i), .en_i(en_q.en2),
        .clr_i(clr2), .val_o(val2), .req_o(req2)
    );
    aic_statreg #(.W(W), .NLVL(0)) u_sth (
        .clk(clk), .rst(rst), .src_i(hev_i), .en_i(en_q.enh),
        .clr_i(clrh), .val_o(valh), .req_o(hd_req_o)
    );

    assign sr_req_o = req1 | req2;

    always_comb begin
        case (off)
            OFF_ST1: rdata_o = val1;
            OFF_ST2: rdata_o = val2;
            OFF_STH: rdata_o = valh;
            OFF_SYN: rdata_o = syn_i;
            OFF_EN1: rdata_o = en_q.en1;
            OFF_EN2: rdata_o = en_q.en2;
            OFF_ENH: rdata_o = en_q.enh;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/aic_top.sv
module aic_top
    import aic_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int W    = REG_W,
    parameter int NALM = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [W-1:0]          wdata_i,
    output logic [W-1:0]          rdata_o,
    output logic                  irq_n_o,
    input  logic [NCH*NALM-1:0]   alm_i,
    input  logic [NCH*(W-NALM)-1:0] ev1_i,
    input  logic [NCH*W-1:0]      ev2_i,
    input  logic [NCH*W-1:0]      hev_i,
    input  logic [NCH*W-1:0]      sync_i
);
    localparam int EVW   = W - NALM;
    localparam int SUM_W = 2 * NCH;

    logic [SUM_W-1:0] summ;
    logic [W-1:0]     ch_rd [NCH];
    logic [W-1:0]     sum_ext;
    logic             chan_space;

    assign chan_space = (addr_i[7:6] == 2'b00);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = chan_space && (addr_i[5:4] == 2'(g));
        aic_chan #(.W(W), .NALM(NALM)) u_ch (
            .clk(clk), .rst(rst),
            .alm_i(alm_i[g*NALM +: NALM]),
            .ev1_i(ev1_i[g*EVW +: EVW]),
            .ev2_i(ev2_i[g*W +: W]),
            .hev_i(hev_i[g*W +: W]),
            .syn_i(sync_i[g*W +: W]),
            .sel_i(sel), .off_i(addr_i[3:0]),
            .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
            .rdata_o(ch_rd[g]),
            .sr_req_o(summ[2*g]),
            .hd_req_o(summ[2*g+1])
        );
    end

    always_comb begin
        sum_ext = '0;
        sum_ext[SUM_W-1:0] = summ;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i[7:6] == 2'b11) begin
            rdata_o = sum_ext;
        end else if (chan_space && (int'(addr_i[5:4]) < NCH)) begin
            rdata_o = ch_rd[addr_i[5:4]];
        end
    end

    assign irq_n_o = ~|summ;
endmodule

// File: rtl/aic_chk.sv
module aic_chk #(
    parameter int NCH  = 4,
    parameter int W    = 8,
    parameter int NALM = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [7:0]              addr_i,
    input logic                    rd_i,
    input logic                    wr_i,
    input logic [W-1:0]            rdata_o,
    input logic                    irq_n_o,
    input logic [NCH*NALM-1:0]     alm_i,
    input logic [NCH*(W-NALM)-1:0] ev1_i,
    input logic [NCH*W-1:0]        ev2_i,
    input logic [NCH*W-1:0]        hev_i,
    input logic [NCH*W-1:0]        sync_i
);
    // R9
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n_o);

    // R7
    sync_live_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i[7:6] == 2'b00 && addr_i[3:0] == 4'd3 && int'(addr_i[5:4]) < NCH)
        |-> rdata_o == sync_i[int'(addr_i[5:4])*W +: W]);

    // R8
    summary_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i[7:6] == 2'b11) |-> ((rdata_o != '0) == !irq_n_o));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n_o) |-> ($past(wr_i || (|ev1_i) || (|ev2_i) || (|hev_i))
                            || ($past(alm_i) != $past(alm_i, 2))));

    // R3
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> $past(rd_i || wr_i));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (addr_i[7:6] == 2'b01 || addr_i[7:6] == 2'b10)) |-> rdata_o == '0);
endmodule

bind aic_top aic_chk #(.NCH(NCH), .W(W), .NALM(NALM)) u_chk (.*);

// File: tb/tb_aic_top.sv
module tb_aic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int WDOG = 20000;
    localparam int NVEC = 25;
    // {op(0 write,1 read,2 pulse), addr, data, expected read, expected irq_n}
    // pulse: addr[5:4] channel, addr[1:0] 0 ev1 / 1 ev2 / 2 hdlc
    localparam logic [26:0] VEC [NVEC] = '{
        {2'd0, 8'h05, 8'hFF, 8'h00, 1'b1},
        {2'd2, 8'h01, 8'h01, 8'h00, 1'b0},
        {2'd1, 8'hC0, 8'h00, 8'h01, 1'b0},
        {2'd1, 8'h01, 8'h00, 8'h01, 1'b1},
        {2'd1, 8'h01, 8'h00, 8'h00, 1'b1},
        {2'd2, 8'h22, 8'h80, 8'h00, 1'b1},
        {2'd1, 8'hFF, 8'h00, 8'h00, 1'b1},
        {2'd0, 8'h26, 8'h80, 8'h00, 1'b0},
        {2'd1, 8'hE5, 8'h00, 8'h20, 1'b0},
        {2'd1, 8'h26, 8'h00, 8'h80, 1'b0},
        {2'd1, 8'h22, 8'h00, 8'h80, 1'b1},
        {2'd2, 8'h10, 8'h04, 8'h00, 1'b1},
        {2'd1, 8'h10, 8'h00, 8'h40, 1'b1},
        {2'd1, 8'h10, 8'h00, 8'h00, 1'b1},
        {2'd0, 8'h45, 8'hFF, 8'h00, 1'b1},
        {2'd1, 8'h45, 8'h00, 8'h00, 1'b1},
        {2'd1, 8'h37, 8'h00, 8'h00, 1'b1},
        {2'd1, 8'h05, 8'h00, 8'hFF, 1'b1},
        {2'd0, 8'h04, 8'hF0, 8'h00, 1'b1},
        {2'd2, 8'h00, 8'h01, 8'h00, 1'b0},
        {2'd2, 8'h01, 8'h02, 8'h00, 1'b0},
        {2'd1, 8'hC3, 8'h00, 8'h01, 1'b0},
        {2'd1, 8'h01, 8'h00, 8'h02, 1'b0},
        {2'd1, 8'h00, 8'h00, 8'h10, 1'b1},
        {2'd1, 8'h04, 8'h00, 8'hF0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       addr = '0;
    logic             rd = 1'b0;
    logic             wr = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             irq_n;
    logic [NCH*4-1:0] alm = '0;
    logic [NCH*4-1:0] ev1 = '0;
    logic [NCH*8-1:0] ev2 = '0;
    logic [NCH*8-1:0] hev = '0;
    logic [NCH*8-1:0] sync = '0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aic_top dut (
        .clk(clk), .rst(rst), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n),
        .alm_i(alm), .ev1_i(ev1), .ev2_i(ev2), .hev_i(hev), .sync_i(sync)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 check(req, rdata, exp);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic do_pulse(int ch, int kind, logic [7:0] d);
        @(negedge clk);
        case (kind)
            0:       ev1[ch*4 +: 4] = d[3:0];
            1:       ev2[ch*8 +: 8] = d;
            default: hev[ch*8 +: 8] = d;
        endcase
        @(negedge clk);
        ev1 = '0; ev2 = '0; hev = '0;
    endtask

    task automatic check_irq(string req, logic exp);
        #1 check(req, {7'd0, irq_n}, {7'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check_irq("R9 irq after reset", 1'b1);
        do_read("R9 summary after reset", 8'hC0, 8'h00);
        do_read("R9 enable after reset", 8'h05, 8'h00);

        // table walk: R2 R3 R5 R6 R8 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] a, d, e;
            logic       q;
            string      tag;
            {op, a, d, e, q} = VEC[i];
            tag = $sformatf("R2/R3/R5/R8/R10 vec%0d", i);
            case (op)
                2'd0:    do_write(a, d);
                2'd1:    do_read(tag, a, e);
                default: do_pulse(int'(a[5:4]), int'(a[1:0]), d);
            endcase
            check_irq($sformatf("R6 irq vec%0d", i), q);
        end

        // R1 alarm on channel 3 bit 0: both edges interrupt
        do_write(8'h34, 8'h01);
        @(negedge clk); alm[12] = 1'b1;
        @(negedge clk);
        check_irq("R1 alarm rise irq", 1'b0);
        do_read("R1 alarm set read", 8'h30, 8'h01);
        check_irq("R3 alarm read releases", 1'b1);
        do_read("R1 alarm persists", 8'h30, 8'h01);
        @(negedge clk); alm[12] = 1'b0;
        @(negedge clk);
        check_irq("R1 alarm fall irq", 1'b0);
        do_read("R1 alarm cleared read", 8'h30, 8'h01);
        do_read("R1 alarm idle read", 8'h30, 8'h00);
        check_irq("R1 irq idle", 1'b1);

        // R4 event coinciding with read of its register
        @(negedge clk);
        addr = 8'h01; rd = 1'b1; ev2[3] = 1'b1;
        #1 check("R4 old value read", rdata, 8'h00);
        @(negedge clk);
        rd = 1'b0; ev2 = '0;
        check_irq("R4 irq kept", 1'b0);
        do_read("R4 bit kept", 8'h01, 8'h08);
        check_irq("R4 released", 1'b1);

        // R7 live synchronizer state
        sync[15:8] = 8'hA5;
        do_read("R7 sync live a", 8'h13, 8'hA5);
        sync[15:8] = 8'h3C;
        do_read("R7 sync live b", 8'h13, 8'h3C);
        do_read("R7 sync unlatched", 8'h13, 8'h3C);
        check_irq("R7 irq untouched", 1'b1);

        // R8 two channels at once
        do_write(8'h36, 8'h01);
        do_pulse(0, 1, 8'h01);
        do_pulse(3, 2, 8'h01);
        do_read("R8 summary two channels", 8'hD7, 8'h81);
        do_read("R8 summary no side effect", 8'hC0, 8'h81);
        check_irq("R6 irq two channels", 1'b0);

        // R9 mid-run reset
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_irq("R9 irq after second reset", 1'b1);
        do_read("R9 summary cleared", 8'hC0, 8'h00);
        do_read("R9 hdlc enable cleared", 8'h26, 8'h00);
        do_read("R9 status cleared", 8'h32, 8'h00);

        finish_run();
    end
endmodule